// File: doc/BRIEF.md
# Serial Bus Clock Generator and Line Control

This block produces the clock for a two-wire serial bus master from a faster parent clock and places each outgoing data bit on the data wire a programmable number of parent cycles after the clock has gone low. A transaction engine raises `run_i` for as long as it wants bit periods. The block returns a sample strobe at each clock rising edge, so the engine can capture incoming bits, and a shift strobe at which it takes the next outgoing bit from `tx_bit_i`. Both wires are open-drain. Each output is a pull-down enable, and an external pull-up gives the high level.

Software can take either wire away from the engine with a per-wire override enable and level. It can also read back the real level of both wires through a synchronizer. The divider and delay fields come in one clock-control word. The override controls and the readback come in a line-control word. The bit positions in both words are fixed, because software decodes them.

The clock is built by a three-state machine: `SC_IDLE`, `SC_LOW` and `SC_HIGH`. In `SC_IDLE` the wire is released. The machine takes `go` from `SC_IDLE` to `SC_LOW` when run is sampled high. It takes `rise` from `SC_LOW` to `SC_HIGH` when a half period has elapsed. At the end of a high half period it takes `fall` back to `SC_LOW` if run is still high, or `stop` to `SC_IDLE` if not. A half period lasts divider+1 parent cycles, so the bus clock runs at the parent frequency divided by 2×(divider+1). At the 3 MHz default bus target the divider is chosen this way. It must keep the bus clock at or below 20 MHz.

Top module: `busclk_line_ctrl`

## Requirements
- R1: While running, every low and every high half period of the bus clock lasts exactly N+1 parent cycles. N is the divider field, ccr_i[7:0], with values 0 to 255.
- R2: The clock wire is released (high) after reset and whenever the machine is idle. The first low half period begins in the cycle after run_i is sampled high. When run_i is low at the end of a high half period, the machine returns to idle. A low half period that is in progress is always completed by its high half.
- R3: sample_o is high for exactly one cycle: the first cycle of each high half period that follows a low half period. It is never high while idle.
- R4: Let D be the delay field, ccr_i[10:8], with 0 treated as 1. shift_o is high in cycle D-1 after the first low cycle of the clock, counting that first low cycle as cycle 0. At the end of that cycle the value of tx_bit_i is captured. The data wire therefore takes the new bit D cycles after the clock fell.
- R5: The engine's data level is high after reset and changes only at the end of a cycle in which shift_o is high.
- R6: When lcr_ctl_i[0] is 1, the data wire follows lcr_ctl_i[1]. When lcr_ctl_i[2] is 1, the clock wire follows lcr_ctl_i[3]. An override takes priority over the engine, and the engine keeps its timing underneath.
- R7: line_rd_o[0] is the data wire level and line_rd_o[1] is the clock wire level, as seen on the input pins two parent clock edges earlier.
- R8: In reset, both pull-down enables are 0 and both strobes are 0.
- R9: The pull-down enables are active high: scl_oe_o or sda_oe_o equal to 1 drives that wire low, and 0 releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transaction engine requests bit periods |
| tx_bit_i | input | 1 | Next outgoing data bit, captured on shift |
| ccr_i | input | 11 | [7:0] divider, [10:8] data-output delay |
| lcr_ctl_i | input | 4 | [0] data override enable, [1] data level, [2] clock override enable, [3] clock level |
| scl_in_i | input | 1 | Clock wire level from the pad |
| sda_in_i | input | 1 | Data wire level from the pad |
| scl_oe_o | output | 1 | Pull-down enable for the clock wire |
| sda_oe_o | output | 1 | Pull-down enable for the data wire |
| line_rd_o | output | 2 | Synchronized readback: [0] data, [1] clock |
| shift_o | output | 1 | One-cycle strobe: data bit captured at this cycle's end |
| sample_o | output | 1 | One-cycle strobe at the bus clock rising edge |

## Verification
The half-period length check assumes that the divider field is changed only while the machine is idle. The stimulus therefore drops run_i and waits more than a full bit period before it writes a new clock-control word. It also keeps the delay at or below divider+1, so that every shift falls inside its own low half period. External wire holding is applied only while idle or while an override owns the wire, so that it cannot disturb the relationship between strobes and clock edges that the checker relies on.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_LOW  = 2'd1,
        SC_HIGH = 2'd2
    } sclk_state_e;

    // Line-control word as software sees it; positions are decoded by software.
    typedef struct packed {
        logic scl_lvl;   // bit 3
        logic scl_en;    // bit 2
        logic sda_lvl;   // bit 1
        logic sda_en;    // bit 0
    } line_ctl_t;

endpackage

// File: rtl/bcl_sclk_fsm.sv
module bcl_sclk_fsm
    import bcl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             scl_eng_o,
    output logic             fall_o,
    output logic             sample_o
);

    sclk_state_e      state_q, state_n;
    logic [DIV_W-1:0] cnt_q, cnt_n;
    logic             half_done;

    assign half_done = (cnt_q == div_i);

    // next-state logic: go, rise, fall, stop
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            SC_IDLE: begin
                cnt_n = '0;
                if (run_i) state_n = SC_LOW;          // go
            end
            SC_LOW: begin
                if (half_done) begin
                    state_n = SC_HIGH;                // rise
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            SC_HIGH: begin
                if (half_done) begin
                    state_n = run_i ? SC_LOW : SC_IDLE; // fall / stop
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                state_n = SC_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        scl_eng_o = (state_q != SC_LOW);
        fall_o    = (state_q != SC_LOW) && (state_n == SC_LOW);
        sample_o  = (state_q == SC_HIGH) && (cnt_q == '0);
    end

endmodule

// File: rtl/bcl_sda_delay.sv
module bcl_sda_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             tx_bit_i,
    output logic             shift_o,
    output logic             sda_eng_o
);

    logic [DLY_W-1:0] wait_q;
    logic [DLY_W-1:0] dly_eff;

    // a programmed delay of zero behaves as one cycle
    assign dly_eff = (dly_i == '0) ? DLY_W'(1) : dly_i;
    assign shift_o = (wait_q == DLY_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wait_q <= '0;
        end else if (fall_i) begin
            wait_q <= dly_eff;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sda_eng_o <= 1'b1;
        end else if (shift_o) begin
            sda_eng_o <= tx_bit_i;
        end
    end

endmodule

// File: rtl/bcl_line_io.sv
module bcl_line_io
    import bcl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      scl_eng_i,
    input  logic      sda_eng_i,
    input  line_ctl_t ctl_i,
    input  logic      scl_in_i,
    input  logic      sda_in_i,
    output logic      scl_oe_o,
    output logic      sda_oe_o,
    output logic [1:0] line_rd_o
);

    logic scl_lvl, sda_lvl;
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;

    always_comb begin
        scl_lvl  = ctl_i.scl_en ? ctl_i.scl_lvl : scl_eng_i;
        sda_lvl  = ctl_i.sda_en ? ctl_i.sda_lvl : sda_eng_i;
        scl_oe_o = ~scl_lvl;
        sda_oe_o = ~sda_lvl;
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                scl_sync[s] <= 1'b1;
                sda_sync[s] <= 1'b1;
            end else if (s == 0) begin
                scl_sync[s] <= scl_in_i;
                sda_sync[s] <= sda_in_i;
            end else begin
                scl_sync[s] <= scl_sync[(s == 0) ? 0 : s-1];
                sda_sync[s] <= sda_sync[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign line_rd_o = {scl_sync[SYNC_STAGES-1], sda_sync[SYNC_STAGES-1]};

endmodule

// File: rtl/busclk_line_ctrl.sv
module busclk_line_ctrl
    import bcl_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DLY_W       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CCR_W      = DIV_W + DLY_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tx_bit_i,
    input  logic [CCR_W-1:0] ccr_i,
    input  logic [3:0]       lcr_ctl_i,
    input  logic             scl_in_i,
    input  logic             sda_in_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic [1:0]       line_rd_o,
    output logic             shift_o,
    output logic             sample_o
);

    logic [DIV_W-1:0] div_f;
    logic [DLY_W-1:0] dly_f;
    line_ctl_t        ctl;
    logic             scl_eng, sda_eng, fall;

    assign div_f = ccr_i[DIV_W-1:0];
    assign dly_f = ccr_i[CCR_W-1:DIV_W];
    assign ctl   = line_ctl_t'(lcr_ctl_i);

    bcl_sclk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .div_i     (div_f),
        .scl_eng_o (scl_eng),
        .fall_o    (fall),
        .sample_o  (sample_o)
    );

    bcl_sda_delay #(.DLY_W(DLY_W)) u_dly (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_i    (fall),
        .dly_i     (dly_f),
        .tx_bit_i  (tx_bit_i),
        .shift_o   (shift_o),
        .sda_eng_o (sda_eng)
    );

    bcl_line_io #(.SYNC_STAGES(SYNC_STAGES)) u_io (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_eng_i (scl_eng),
        .sda_eng_i (sda_eng),
        .ctl_i     (ctl),
        .scl_in_i  (scl_in_i),
        .sda_in_i  (sda_in_i),
        .scl_oe_o  (scl_oe_o),
        .sda_oe_o  (sda_oe_o),
        .line_rd_o (line_rd_o)
    );

endmodule

// File: rtl/busclk_line_chk.sv
module busclk_line_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [DIV_W-1:0] div_f,
    input logic             scl_eng,
    input logic             sda_eng,
    input logic             sample_o,
    input logic             shift_o,
    input logic [3:0]       lcr_ctl_i,
    input logic             scl_oe_o
);

    logic [DIV_W:0] low_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      low_len <= '0;
        else if (scl_eng) low_len <= '0;
        else              low_len <= low_len + 1'b1;
    end

    a_r1_low_half_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_eng) |-> (low_len == ({1'b0, div_f} + 1'b1)));

    a_r3_sample_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (scl_eng && !$past(scl_eng)));

    a_r4_shift_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_o |=> !shift_o);

    a_r5_sda_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(shift_o) |-> $stable(sda_eng));

    a_r6_scl_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lcr_ctl_i[2] |-> (scl_oe_o == !lcr_ctl_i[3]));

endmodule

bind busclk_line_ctrl busclk_line_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_f     (div_f),
    .scl_eng   (scl_eng),
    .sda_eng   (sda_eng),
    .sample_o  (sample_o),
    .shift_o   (shift_o),
    .lcr_ctl_i (lcr_ctl_i),
    .scl_oe_o  (scl_oe_o)
);

// File: tb/tb_busclk_line_ctrl.sv
`timescale 1ns/1ps
module tb_busclk_line_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        tx_bit = 1'b0;
    logic [10:0] ccr = '0;
    logic [3:0]  lcr = '0;
    logic        hold_scl = 1'b0, hold_sda = 1'b0;
    logic        scl_oe, sda_oe, shift, sample;
    logic [1:0]  line_rd;
    logic        scl_pad, sda_pad;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit finished = 0;
    bit cmp_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    assign scl_pad = ~scl_oe & ~hold_scl;
    assign sda_pad = ~sda_oe & ~hold_sda;

    busclk_line_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tx_bit_i(tx_bit),
        .ccr_i(ccr), .lcr_ctl_i(lcr), .scl_in_i(scl_pad), .sda_in_i(sda_pad),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .line_rd_o(line_rd),
        .shift_o(shift), .sample_o(sample)
    );

    // behavioural reference: mode 0 idle, 1 clock low, 2 clock high
    int m_mode, m_age, m_wait;
    bit m_sda;
    bit [1:0] m_h1, m_h2;

    initial begin
        m_mode = 0; m_age = 0; m_wait = 0; m_sda = 1; m_h1 = 2'b11; m_h2 = 2'b11;
    end

    always @(posedge clk) begin
        int  div, d;
        bit  went_low, shift_now;
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_wait = 0; m_sda = 1; m_h1 = 2'b11; m_h2 = 2'b11;
        end else begin
            div = int'(ccr[7:0]);
            d = (ccr[10:8] == 0) ? 1 : int'(ccr[10:8]);
            went_low = 0;
            shift_now = (m_wait == 1);
            m_h2 = m_h1;
            m_h1 = {scl_pad, sda_pad};
            if (m_mode == 0) begin
                if (run) begin m_mode = 1; m_age = 0; went_low = 1; end
            end else if (m_age == div) begin
                m_age = 0;
                if (m_mode == 1) m_mode = 2;
                else if (run) begin m_mode = 1; went_low = 1; end
                else m_mode = 0;
            end else begin
                m_age = m_age + 1;
            end
            if (shift_now) m_sda = tx_bit;
            if (went_low) m_wait = d;
            else if (m_wait > 0) m_wait = m_wait - 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit scl_l, sda_l;
        if (cmp_on && !finished) begin
            scl_l = lcr[2] ? lcr[3] : (m_mode != 1);
            sda_l = lcr[0] ? lcr[1] : m_sda;
            chk(lcr[2] ? "R6 R9 clock override" : "R1 R2 R9 clock wire", int'(scl_oe), int'(!scl_l));
            chk(lcr[0] ? "R6 R9 data override" : "R4 R5 R9 data wire", int'(sda_oe), int'(!sda_l));
            chk("R3 sample strobe", int'(sample), int'(m_mode == 2 && m_age == 0));
            chk("R4 shift strobe", int'(shift), int'(m_wait == 1));
            chk("R7 readback", int'(line_rd), int'(m_h2));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_bit = lfsr[0];
        end
    endtask

    task automatic burst(input int div, input int dly, input int n);
        ccr = 11'((dly << 8) | div);
        run = 1'b1;
        tick(n);
        run = 1'b0;
        tick(2 * (div + 1) + 4);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R8: reset values
        chk("R8 reset clock enable", int'(scl_oe), 0);
        chk("R8 reset data enable", int'(sda_oe), 0);
        chk("R8 reset sample", int'(sample), 0);
        chk("R8 reset shift", int'(shift), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        tick(4);
        burst(3, 2, 40);         // R1 R4
        burst(0, 0, 20);         // R1 R4 delay zero as one
        burst(5, 6, 60);         // R4 longest delay within half period
        // R6 overrides while running
        ccr = 11'((4 << 8) | 6);
        run = 1'b1;
        lcr = 4'b0001; tick(15);
        lcr = 4'b0011; tick(15);
        lcr = 4'b0100; tick(15);
        lcr = 4'b1100; tick(15);
        lcr = 4'b0000; tick(10);
        run = 1'b0; tick(20);
        // R7 external holds while idle
        hold_scl = 1'b1; tick(5);
        hold_sda = 1'b1; tick(5);
        hold_scl = 1'b0; tick(5);
        hold_sda = 1'b0; tick(5);
        // R2 run dropped inside a low half period
        burst(7, 3, 3);
        // R1 widest divider
        burst(255, 7, 1100);
        // R2 irregular run pattern
        ccr = 11'((1 << 8) | 2);
        for (int i = 0; i < 300; i++) begin
            run = lfsr[3] | lfsr[7];
            tick(1);
        end
        run = 1'b0; tick(12);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule